// File: doc/BRIEF.md
# RF Transmitter Power-Up Sequencer

This block is the digital control core of a crystal-referenced UHF transmitter. Three control inputs select the operating mode: an amplitude-keying request, a frequency-keying request, and a three-state enable that can be driven low, driven high or left open. From these, the block drives the enable for the oscillator and PLL, the enable for the power amplifier, and the state of the capacitor switch used to pull the crystal for frequency keying. An idle mode lets the two keying lines be reused for other purposes while the enable is held low.

Once powered, the block divides its input clock (the crystal-domain clock) by a parameterised ratio and presents the result as a reference clock for a host controller. That clock stays low until a synchronised oscillator-amplitude-good flag is seen. It then starts only at a divider boundary, so its first cycle is never shortened. A lock wait, counted in reference-clock periods, is timed from that start, and at its end the transmit-ready flag rises. Losing the internal enable drops everything back to power-down at once.

Top module: `rftx_seq`

## Requirements
- R1: With both keying inputs low and the enable low or open, the block is powered down: `osc_pll_en_o`, `pa_en_o` and `fsk_sw_closed_o` are 0 (switch open).
- R2: Enable code 2'b10 (open, and 2'b11 treated the same) powers the block up exactly when `ask_i` or `fsk_i` is 1.
- R3: Enable code 2'b01 (high) powers the block up whatever the keying inputs are.
- R4: Enable code 2'b00 (low) with either keying input high is idle: all three enables are 0, the switch is open, and `ref_clk_o` and `tx_ready_o` stay 0.
- R5: While powered, `pa_en_o` equals `ask_i` and `fsk_sw_closed_o` equals the inverse of `fsk_i`; `osc_pll_en_o` is 1.
- R6: `ref_clk_o` is 0 whenever the block is not powered, and after power-up stays 0 until `amp_ok_i` has passed a two-flop synchroniser; it then starts between 3 and DIV+2 cycles after `amp_ok_i` rises.
- R7: `ref_clk_o` is the input clock divided by DIV (default 8), high for DIV/2 cycles then low for DIV/2; its first high phase is a full DIV/2 cycles.
- R8: `tx_ready_o` rises exactly DIV*LOCK_CYCLES input cycles after the first rising edge of `ref_clk_o` and stays high while powered.
- R9: When the internal enable falls, by the next clock edge `ref_clk_o` and `tx_ready_o` are 0 and divider, gate and lock count are cleared; a new power-up repeats the whole sequence with the same timing.
- R10: Once `ref_clk_o` has started, later changes on `amp_ok_i` do not stop it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-domain input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ask_i | input | 1 | Amplitude-keying request, turns the PA on when powered |
| fsk_i | input | 1 | Frequency-keying request, 1 opens the pulling switch |
| en_mode_i | input | 2 | Enable state: 00 low, 01 high, 10 or 11 open |
| amp_ok_i | input | 1 | Oscillator amplitude good (asynchronous) |
| osc_pll_en_o | output | 1 | Oscillator and PLL enable |
| pa_en_o | output | 1 | Power amplifier enable |
| fsk_sw_closed_o | output | 1 | 1 = pulling switch closed (low impedance) |
| ref_clk_o | output | 1 | Gated divided reference clock |
| tx_ready_o | output | 1 | Lock wait elapsed, transmission may start |

## Verification
On every cycle the assertions check the mode decode against the enables, that the power amplifier is never on without the oscillator, that the gated clock only starts from a synchronised amplitude flag and always starts high, that every high phase lasts exactly DIV/2 cycles unless power is cut, and that a power loss clears the clock and ready flag on the next edge. The exact number of cycles from the first clock edge to ready, the latency window after the amplitude flag, the persistence of the clock after the flag drops and the repeat of the full sequence after a power cycle are shown only by the bench's scenarios, which also sweep all sixteen combinations of the mode inputs.

// File: rtl/rftx_pkg.sv
package rftx_pkg;

  typedef enum logic [1:0] {
    EN_LOW   = 2'b00,
    EN_HIGH  = 2'b01,
    EN_OPEN  = 2'b10,
    EN_OPEN2 = 2'b11
  } en_mode_e;

  // Internal enable from the three-state pin and the keying lines.
  function automatic logic power_request(input logic [1:0] mode,
                                         input logic ask,
                                         input logic fsk);
    logic req;
    case (en_mode_e'(mode))
      EN_LOW:  req = 1'b0;
      EN_HIGH: req = 1'b1;
      default: req = ask | fsk;
    endcase
    return req;
  endfunction

  // Divider phase that drives the reference clock high.
  function automatic logic phase_high(input int unsigned phase,
                                      input int unsigned div);
    return phase < (div / 2);
  endfunction

endpackage

// File: rtl/rftx_mode_dec.sv
module rftx_mode_dec (
  input  logic [1:0] en_mode_i,
  input  logic       ask_i,
  input  logic       fsk_i,
  output logic       pwr_on_o,
  output logic       osc_en_o,
  output logic       pa_en_o,
  output logic       sw_closed_o
);
  import rftx_pkg::*;

  always_comb begin
    pwr_on_o    = power_request(en_mode_i, ask_i, fsk_i);
    osc_en_o    = pwr_on_o;
    pa_en_o     = pwr_on_o & ask_i;
    sw_closed_o = pwr_on_o & ~fsk_i;
  end
endmodule

// File: rtl/rftx_sync.sv
module rftx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    chain_q <= '0;
    else if (clr_i) chain_q <= '0;
    else            chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rftx_clkgate.sv
module rftx_clkgate #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic amp_ok_i,
  output logic ref_clk_o,
  output logic gate_on_o,
  output logic arm_evt_o,
  output logic period_done_o
);
  import rftx_pkg::*;

  localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          gate_q, gate_d, ref_q, wrap;

  always_comb begin
    wrap          = (div_q == LAST);
    div_d         = wrap ? '0 : div_q + 1'b1;
    arm_evt_o     = run_i & ~gate_q & amp_ok_i & wrap;
    gate_d        = gate_q | arm_evt_o;
    period_done_o = run_i & gate_q & wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      gate_q <= 1'b0;
      ref_q  <= 1'b0;
    end else if (!run_i) begin
      div_q  <= '0;
      gate_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      gate_q <= gate_d;
      ref_q  <= gate_d & phase_high(32'(div_d), DIV);
    end
  end

  assign ref_clk_o = ref_q;
  assign gate_on_o = gate_q;
endmodule

// File: rtl/rftx_lock_timer.sv
module rftx_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 410
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int unsigned LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] FINAL = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (tick_i && !ready_q) begin
      if (cnt_q == FINAL) ready_q <= 1'b1;
      else                cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/rftx_seq.sv
module rftx_seq #(
  parameter int unsigned DIV         = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOCK_CYCLES = 410
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ask_i,
  input  logic       fsk_i,
  input  logic [1:0] en_mode_i,
  input  logic       amp_ok_i,
  output logic       osc_pll_en_o,
  output logic       pa_en_o,
  output logic       fsk_sw_closed_o,
  output logic       ref_clk_o,
  output logic       tx_ready_o
);
  // Named internal events, observed by the bound checker.
  logic pwr_on;
  logic amp_ok_s;
  logic gate_on;
  logic arm_evt;
  logic period_done;

  rftx_mode_dec u_dec (
    .en_mode_i  (en_mode_i),
    .ask_i      (ask_i),
    .fsk_i      (fsk_i),
    .pwr_on_o   (pwr_on),
    .osc_en_o   (osc_pll_en_o),
    .pa_en_o    (pa_en_o),
    .sw_closed_o(fsk_sw_closed_o)
  );

  rftx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~pwr_on),
    .d_i   (amp_ok_i),
    .q_o   (amp_ok_s)
  );

  rftx_clkgate #(.DIV(DIV)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (pwr_on),
    .amp_ok_i     (amp_ok_s),
    .ref_clk_o    (ref_clk_o),
    .gate_on_o    (gate_on),
    .arm_evt_o    (arm_evt),
    .period_done_o(period_done)
  );

  rftx_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (pwr_on),
    .tick_i (period_done),
    .ready_o(tx_ready_o)
  );
endmodule

// File: rtl/rftx_seq_chk.sv
module rftx_seq_chk #(
  parameter int unsigned DIV = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ask_i,
  input logic       fsk_i,
  input logic [1:0] en_mode_i,
  input logic       osc_pll_en_o,
  input logic       pa_en_o,
  input logic       fsk_sw_closed_o,
  input logic       ref_clk_o,
  input logic       tx_ready_o,
  input logic       pwr_on,
  input logic       amp_ok_s,
  input logic       gate_on,
  input logic       arm_evt
);
  localparam int unsigned HW = $clog2(DIV + 1) + 1;
  localparam logic [HW-1:0] HALF = HW'(DIV / 2);

  logic [HW-1:0] hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_run <= '0;
    else if (ref_clk_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  assert_pwrdn_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ask_i && !fsk_i && en_mode_i != 2'b01)
      |-> (!osc_pll_en_o && !pa_en_o && !fsk_sw_closed_o));

  assert_open_follows_keys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_mode_i[1] |-> (osc_pll_en_o == (ask_i | fsk_i)));

  assert_high_forces_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mode_i == 2'b01) |-> osc_pll_en_o);

  assert_idle_all_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_mode_i == 2'b00) |-> (!osc_pll_en_o && !pa_en_o && !fsk_sw_closed_o));

  assert_pa_needs_osc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pa_en_o |-> (osc_pll_en_o && ask_i));

  assert_gate_from_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_on) |-> $past(amp_ok_s));

  assert_arm_only_powered_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_evt |-> pwr_on);

  assert_start_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_on) |-> ref_clk_o);

  assert_high_phase_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ref_clk_o) && $past(pwr_on)) |-> (hi_run == HALF));

  assert_high_no_overrun_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= HALF);

  assert_ready_after_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> gate_on);

  assert_ready_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && pwr_on) |=> tx_ready_o);

  assert_loss_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on |=> (!ref_clk_o && !tx_ready_o && !gate_on));
endmodule

bind rftx_seq rftx_seq_chk #(.DIV(DIV)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ask_i          (ask_i),
  .fsk_i          (fsk_i),
  .en_mode_i      (en_mode_i),
  .osc_pll_en_o   (osc_pll_en_o),
  .pa_en_o        (pa_en_o),
  .fsk_sw_closed_o(fsk_sw_closed_o),
  .ref_clk_o      (ref_clk_o),
  .tx_ready_o     (tx_ready_o),
  .pwr_on         (pwr_on),
  .amp_ok_s       (amp_ok_s),
  .gate_on        (gate_on),
  .arm_evt        (arm_evt)
);

// File: tb/rftx_seq_test.sv
module rftx_seq_test;
  localparam int DIV  = 8;
  localparam int LOCK = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ask = 1'b0, fsk = 1'b0, amp = 1'b0;
  logic [1:0] en = 2'b00;
  logic       osc, pa, sw, rclk, rdy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  rftx_seq #(.DIV(DIV), .SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ask_i(ask), .fsk_i(fsk), .en_mode_i(en),
    .amp_ok_i(amp), .osc_pll_en_o(osc), .pa_en_o(pa), .fsk_sw_closed_o(sw),
    .ref_clk_o(rclk), .tx_ready_o(rdy)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Waits for ref_clk_o high; returns the cycle stamp and the wait length.
  task automatic wait_rise(output int stamp, output int waited);
    waited = 0;
    while (!rclk && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    stamp = cyc;
  endtask

  // Full start-up run: amplitude flag, first period shape, lock wait.
  task automatic startup_run(input string tag);
    int t0, w, hi, lo, tr;
    amp = 1'b1;
    wait_rise(t0, w);
    check(w >= 3 && w <= DIV + 2, {"R6 start latency ", tag}, w, 3);
    hi = 0;
    while (rclk && hi < 50) begin @(negedge clk); hi++; end
    check(hi == DIV / 2, {"R7 first high ", tag}, hi, DIV / 2);
    lo = 0;
    while (!rclk && lo < 50) begin @(negedge clk); lo++; end
    check(lo == DIV / 2, {"R7 first low ", tag}, lo, DIV / 2);
    tr = 0;
    while (!rdy && tr < 2000) begin @(negedge clk); tr++; end
    check(cyc - t0 == DIV * LOCK, {"R8 ready delay ", tag}, cyc - t0, DIV * LOCK);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int rises;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!osc && !pa && !sw && !rclk && !rdy, "R1 reset state",
          {osc, pa, sw, rclk, rdy}, 0);

    // Mode table sweep with amplitude flag held low.
    for (int v = 0; v < 16; v++) begin
      logic e_on, e_pa, e_sw;
      en  = 2'(v >> 2);
      ask = v[1];
      fsk = v[0];
      @(negedge clk);
      e_on = (en == 2'b00) ? 1'b0 : (en == 2'b01) ? 1'b1 : (ask | fsk);
      e_pa = ask && e_on;
      e_sw = e_on && !fsk;
      if (en == 2'b00)      check(osc == 1'b0 && pa == 1'b0 && sw == 1'b0, "R4 idle/off", {osc, pa, sw}, 0);
      else if (en == 2'b01) check(osc == 1'b1, "R3 high enable", osc, 1);
      else                  check(osc == e_on, "R2 open enable", osc, e_on);
      if (!ask && !fsk && en != 2'b01)
        check(osc == 1'b0 && sw == 1'b0, "R1 power-down", {osc, sw}, 0);
      check(pa == e_pa && sw == e_sw, "R5 pa/switch", {pa, sw}, {e_pa, e_sw});
      check(!rclk && !rdy, "R6 clock low without amp", {rclk, rdy}, 0);
    end

    // Open enable, FSK high: powered, clock held until amplitude ok.
    en = 2'b10; ask = 1'b0; fsk = 1'b1; amp = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 4) check(!rclk, "R6 held low before amp", rclk, 0);
    end
    startup_run("open");

    // Amplitude flag drops: clock must keep running, ready held.
    amp = 1'b0;
    rises = 0;
    prev = rclk;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (rclk && !prev) rises++;
      prev = rclk;
    end
    check(rises == 4, "R10 clock survives amp drop", rises, 4);
    check(rdy == 1'b1, "R8 ready held", rdy, 1);

    // Keying while powered.
    ask = 1'b1;
    @(negedge clk);
    check(pa == 1'b1 && sw == 1'b0, "R5 ask on, fsk high", {pa, sw}, 2'b10);
    fsk = 1'b0;
    @(negedge clk);
    check(pa == 1'b1 && sw == 1'b1 && osc == 1'b1, "R5 fsk low closes", {osc, pa, sw}, 3'b111);

    // Power loss.
    ask = 1'b0;
    @(negedge clk);
    check(!rclk && !rdy && !osc, "R9 loss clears", {osc, rclk, rdy}, 0);
    repeat (5) @(negedge clk);
    check(!rclk && !rdy, "R9 stays cleared", {rclk, rdy}, 0);

    // Re-power with enable high and no keying.
    en = 2'b01;
    repeat (12) @(negedge clk);
    check(!rclk, "R6 held low after repower", rclk, 0);
    startup_run("repower");

    // Drop to idle with keying active.
    en = 2'b00; ask = 1'b1; fsk = 1'b1;
    @(negedge clk);
    check(!osc && !pa && !sw && !rclk && !rdy, "R4 idle clears",
          {osc, pa, sw, rclk, rdy}, 0);
    repeat (10) @(negedge clk);
    check(!rclk && !rdy, "R4 idle stays quiet", {rclk, rdy}, 0);

    finish_run();
  end
endmodule